// File: doc/BRIEF.md
# Block Change Detector for Conditional Replenishment

This block sits at the front of a low-rate moving-picture coder. It receives a subsampled luminance frame as a pixel stream and reads the co-located pixel of the stored reference frame in the same cycle. It sums absolute pixel differences over each 8x8 block. When a block's sum exceeds a programmable threshold, it marks the block as changed. Only changed blocks go on to transform coding. The per-block flag also serves as the write enable with which the external reference store replaces that block.

At the end of every coded frame, the block reports how many blocks changed. It then picks one of five quantizer step sizes from that count, using four programmable count thresholds: more changed blocks give a coarser step. At each frame start, the block decides whether to drop the incoming frame. It drops the frame when the output buffer is too full, with high and low water marks giving hysteresis. It also drops the frame when it arrives sooner than the minimum frame interval (25 frames per second at the default clock). A dropped frame produces no block results.

Top module: `blkChangeDetect`

## Requirements
- R1: After reset, blkValid, blkChanged, frameDone and skipFrame are 0, and changedCount and quantStep are 0.
- R2: refAddr always equals line*FRAME_W + column of the pixel on pixData in the same cycle. refData is taken in that cycle. A pixel with pixSof set is line 0, column 0. A pixel with pixSol set starts the next line.
- R3: A block is changed when the sum of |pixData - refData| over its pixels is strictly greater than sadThr. A sum equal to sadThr is unchanged. Differences of either sign count by magnitude.
- R4: The frame is split into ceil(FRAME_W/8) block columns and FRAME_H/8 block rows. The rightmost, narrower column is summed only over the pixels that exist; its missing pixels count as zero difference.
- R5: A block result (blkValid=1 with blkChanged, blkCol, blkRow) appears one cycle after the last pixel of that block on the eighth line of its block row. Results come in raster order.
- R6: One cycle after the last pixel of a coded frame, frameDone pulses together with the last block result. changedCount then holds the number of changed blocks in that frame.
- R7: At frameDone, quantStep = QMIN << L, where L is the number of the four count thresholds that changedCount strictly exceeds (0..4).
- R8: The buffer decision is taken at each frame start. If bufLevel > hiMark, the frame is skipped. If bufLevel < loMark, the frame is coded. Otherwise the previous frame's buffer decision is kept. skipFrame shows the decision from the cycle after the frame start until the next frame start.
- R9: A frame whose start comes fewer than MIN_GAP cycles after the start of the last coded frame is skipped. The default MIN_GAP of 2,000,000 cycles is 25 Hz at 50 MHz.
- R10: A skipped frame produces no block result and no frameDone. changedCount and quantStep keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel present on pixData |
| pixSof | input | 1 | First pixel of a frame (with pixSol) |
| pixSol | input | 1 | First pixel of a line |
| pixData | input | PIX_W | Incoming luminance pixel |
| refAddr | output | ADDR_W | Reference-frame read address of the current pixel |
| refData | input | PIX_W | Reference pixel at refAddr, same cycle |
| bufLevel | input | BUF_W | Output buffer fill level |
| hiMark | input | BUF_W | Fill above which frames are dropped |
| loMark | input | BUF_W | Fill below which coding resumes |
| sadThr | input | SAD_W | Block change threshold |
| cntThr0 | input | CNT_W | Count threshold 0 |
| cntThr1 | input | CNT_W | Count threshold 1 |
| cntThr2 | input | CNT_W | Count threshold 2 |
| cntThr3 | input | CNT_W | Count threshold 3 |
| blkValid | output | 1 | Block result present |
| blkChanged | output | 1 | Block changed; also the reference replace enable |
| blkCol | output | COL_W | Block column of the result |
| blkRow | output | ROW_W | Block row of the result |
| skipFrame | output | 1 | Current frame is dropped |
| frameDone | output | 1 | End of coded frame |
| changedCount | output | CNT_W | Changed blocks in the last coded frame |
| quantStep | output | STEP_W | Quantizer step for the last coded frame |

## Verification
The hardest case to reach from the ports is the hysteresis band. There, the drop decision depends on a state set by an earlier frame. The stimulus raises the fill above the high mark for one frame, then parks it between the marks for the next. It fills both dropped frames with heavily altered pixels, so any stray block result would stand out. The rate cap is reached by starting a frame a few idle cycles after a coded one, with the buffer low, so that only the interval can be the cause.

// File: rtl/crDetectPkg.sv
package crDetectPkg;
  localparam int IDX_W = 8;
  localparam int NUM_CNT_THR = 4;

  typedef struct packed {
    logic pix;
    logic clear;
    logic blkEnd;
    logic lastBlk;
    logic [IDX_W-1:0] col;
    logic [IDX_W-1:0] row;
  } crStrobe_t;
endpackage

// File: rtl/crCtrl.sv
module crCtrl
  import crDetectPkg::*;
#(
  parameter int FRAME_W = 180,
  parameter int FRAME_H = 144,
  parameter int BLK = 8,
  parameter int BUF_W = 16,
  parameter int MIN_GAP = 2000000,
  localparam int XW = $clog2(FRAME_W),
  localparam int YW = $clog2(FRAME_H),
  localparam int LB = $clog2(BLK),
  localparam int ADDR_W = $clog2(FRAME_W * FRAME_H),
  localparam int GAP_W = $clog2(MIN_GAP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic              pixSof,
  input  logic              pixSol,
  input  logic [BUF_W-1:0]  bufLevel,
  input  logic [BUF_W-1:0]  hiMark,
  input  logic [BUF_W-1:0]  loMark,
  output logic [ADDR_W-1:0] refAddr,
  output crStrobe_t         strobe,
  output logic              skipFrame
);
  logic [XW-1:0] lastX, curX;
  logic [YW-1:0] lastY, curY;
  logic [GAP_W-1:0] gapCnt, gapNext;
  logic skipState, frameOn;
  logic sof, bufNext, rateOk, sofSkip, curSkip, active;
  logic atLastCol, blkEnd, lastBlk;

  assign sof = pixValid & pixSof;

  // position of the pixel on the input this cycle
  always_comb begin
    curX = pixSol ? '0 : lastX + XW'(1);
    if (pixSof) curY = '0;
    else if (pixSol) curY = lastY + YW'(1);
    else curY = lastY;
  end

  assign refAddr = ADDR_W'(int'(curY) * FRAME_W + int'(curX));

  // drop decision: buffer hysteresis plus minimum frame interval
  always_comb begin
    if (bufLevel > hiMark) bufNext = 1'b1;
    else if (bufLevel < loMark) bufNext = 1'b0;
    else bufNext = skipState;
  end

  assign rateOk  = gapCnt >= GAP_W'(MIN_GAP);
  assign sofSkip = bufNext | ~rateOk;
  assign curSkip = pixSof ? sofSkip : skipFrame;
  assign active  = pixValid & ~curSkip & (pixSof | frameOn);
  assign gapNext = rateOk ? gapCnt : gapCnt + GAP_W'(1);

  assign atLastCol = curX == XW'(FRAME_W - 1);
  assign blkEnd    = active & (&curY[LB-1:0]) & ((&curX[LB-1:0]) | atLastCol);
  assign lastBlk   = blkEnd & atLastCol & (curY == YW'(FRAME_H - 1));

  always_comb begin
    strobe.pix     = active;
    strobe.clear   = sof;
    strobe.blkEnd  = blkEnd;
    strobe.lastBlk = lastBlk;
    strobe.col     = IDX_W'(curX >> LB);
    strobe.row     = IDX_W'(curY >> LB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastX     <= '0;
      lastY     <= '0;
      skipState <= 1'b0;
      skipFrame <= 1'b0;
      frameOn   <= 1'b0;
      gapCnt    <= GAP_W'(MIN_GAP);
    end else begin
      if (pixValid) begin
        lastX <= curX;
        lastY <= curY;
      end
      if (sof) begin
        skipState <= bufNext;
        skipFrame <= sofSkip;
        frameOn   <= ~sofSkip & ~lastBlk;
        gapCnt    <= sofSkip ? gapNext : GAP_W'(1);
      end else begin
        gapCnt <= gapNext;
        if (lastBlk) frameOn <= 1'b0;
      end
    end
  end

  // R8: decision is held for the whole frame
  p_skip_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(pixValid && pixSof) |=> $stable(skipFrame));
  // R8: overfull buffer drops the frame
  p_high_skips_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixSof && bufLevel > hiMark) |=> skipFrame);
  // R8: drained buffer with interval met codes the frame
  p_low_codes_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixSof && bufLevel < loMark && rateOk) |=> !skipFrame);
  // R9: early frame is dropped
  p_rate_cap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixSof && gapCnt < GAP_W'(MIN_GAP)) |=> skipFrame);
endmodule

// File: rtl/crDatapath.sv
module crDatapath
  import crDetectPkg::*;
#(
  parameter int NCOL = 23,
  parameter int NROW = 18,
  parameter int PIX_W = 8,
  parameter int SAD_W = 14,
  parameter int CNT_W = 9,
  parameter int STEP_W = 8,
  parameter int QMIN = 2,
  localparam int COL_W = $clog2(NCOL),
  localparam int ROW_W = $clog2(NROW)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  crStrobe_t                         strobe,
  input  logic [PIX_W-1:0]                  pixData,
  input  logic [PIX_W-1:0]                  refData,
  input  logic [SAD_W-1:0]                  sadThr,
  input  logic [NUM_CNT_THR-1:0][CNT_W-1:0] cntThr,
  output logic                              blkValid,
  output logic                              blkChanged,
  output logic [COL_W-1:0]                  blkCol,
  output logic [ROW_W-1:0]                  blkRow,
  output logic                              frameDone,
  output logic [CNT_W-1:0]                  changedCount,
  output logic [STEP_W-1:0]                 quantStep
);
  localparam int LVL_W = $clog2(NUM_CNT_THR + 1);

  logic [SAD_W-1:0] acc [NCOL];
  logic [PIX_W-1:0] diff;
  logic [SAD_W-1:0] colSum, blockSum;
  logic changedNow;
  logic [CNT_W-1:0] runCount, frameCount;
  logic [NUM_CNT_THR-1:0] over;
  logic [LVL_W-1:0] level;
  logic [STEP_W-1:0] stepNow;

  assign diff = (pixData >= refData) ? pixData - refData : refData - pixData;

  always_comb begin
    colSum = '0;
    for (int c = 0; c < NCOL; c++)
      if (strobe.col == IDX_W'(c)) colSum = acc[c];
  end

  assign blockSum   = colSum + SAD_W'(diff);
  assign changedNow = strobe.blkEnd & (blockSum > sadThr);
  assign frameCount = runCount + CNT_W'(changedNow);

  // one comparator per count threshold
  for (genvar k = 0; k < NUM_CNT_THR; k++) begin : g_thr
    assign over[k] = frameCount > cntThr[k];
  end

  always_comb begin
    level = '0;
    for (int k = 0; k < NUM_CNT_THR; k++)
      level = level + LVL_W'(over[k]);
    stepNow = STEP_W'(QMIN) << level;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NCOL; c++) acc[c] <= '0;
      runCount     <= '0;
      blkValid     <= 1'b0;
      blkChanged   <= 1'b0;
      blkCol       <= '0;
      blkRow       <= '0;
      frameDone    <= 1'b0;
      changedCount <= '0;
      quantStep    <= '0;
    end else begin
      for (int c = 0; c < NCOL; c++) begin
        if (strobe.pix && strobe.col == IDX_W'(c))
          acc[c] <= strobe.blkEnd ? '0 :
                    (strobe.clear ? SAD_W'(diff) : acc[c] + SAD_W'(diff));
        else if (strobe.clear)
          acc[c] <= '0;
      end
      if (strobe.clear) runCount <= '0;
      else if (changedNow) runCount <= runCount + CNT_W'(1);
      blkValid   <= strobe.blkEnd;
      blkChanged <= changedNow;
      if (strobe.blkEnd) begin
        blkCol <= COL_W'(strobe.col);
        blkRow <= ROW_W'(strobe.row);
      end
      frameDone <= strobe.lastBlk;
      if (strobe.lastBlk) begin
        changedCount <= frameCount;
        quantStep    <= stepNow;
      end
    end
  end

  // R6: frame end coincides with the bottom-right block result
  p_done_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (blkValid && blkCol == COL_W'(NCOL - 1) && blkRow == ROW_W'(NROW - 1)));
  // R6: count never exceeds the number of blocks
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> changedCount <= CNT_W'(NCOL * NROW));
  // R7: a count at or below every threshold gives the finest step
  p_step_floor_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && changedCount <= cntThr[0] && changedCount <= cntThr[1] &&
     changedCount <= cntThr[2] && changedCount <= cntThr[3] && $stable(cntThr))
    |-> quantStep == STEP_W'(QMIN));
  // R5: a block result lasts a single cycle when blocks are 8 wide
  p_blk_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && blkCol != COL_W'(NCOL - 1)) |=> !blkValid);
endmodule

// File: rtl/blkChangeDetect.sv
module blkChangeDetect
  import crDetectPkg::*;
#(
  parameter int FRAME_W = 180,
  parameter int FRAME_H = 144,
  parameter int BLK = 8,
  parameter int PIX_W = 8,
  parameter int BUF_W = 16,
  parameter int STEP_W = 8,
  parameter int QMIN = 2,
  parameter int MIN_GAP = 2000000,
  localparam int NCOL = (FRAME_W + BLK - 1) / BLK,
  localparam int NROW = FRAME_H / BLK,
  localparam int NBLK = NCOL * NROW,
  localparam int COL_W = $clog2(NCOL),
  localparam int ROW_W = $clog2(NROW),
  localparam int CNT_W = $clog2(NBLK + 1),
  localparam int SAD_W = $clog2(BLK * BLK * ((1 << PIX_W) - 1) + 1),
  localparam int ADDR_W = $clog2(FRAME_W * FRAME_H)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixValid,
  input  logic              pixSof,
  input  logic              pixSol,
  input  logic [PIX_W-1:0]  pixData,
  output logic [ADDR_W-1:0] refAddr,
  input  logic [PIX_W-1:0]  refData,
  input  logic [BUF_W-1:0]  bufLevel,
  input  logic [BUF_W-1:0]  hiMark,
  input  logic [BUF_W-1:0]  loMark,
  input  logic [SAD_W-1:0]  sadThr,
  input  logic [CNT_W-1:0]  cntThr0,
  input  logic [CNT_W-1:0]  cntThr1,
  input  logic [CNT_W-1:0]  cntThr2,
  input  logic [CNT_W-1:0]  cntThr3,
  output logic              blkValid,
  output logic              blkChanged,
  output logic [COL_W-1:0]  blkCol,
  output logic [ROW_W-1:0]  blkRow,
  output logic              skipFrame,
  output logic              frameDone,
  output logic [CNT_W-1:0]  changedCount,
  output logic [STEP_W-1:0] quantStep
);
  crStrobe_t strobe;
  logic [NUM_CNT_THR-1:0][CNT_W-1:0] thrPack;

  assign thrPack = {cntThr3, cntThr2, cntThr1, cntThr0};

  crCtrl #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .BLK(BLK),
    .BUF_W(BUF_W), .MIN_GAP(MIN_GAP)
  ) ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixSof(pixSof),
    .pixSol(pixSol), .bufLevel(bufLevel), .hiMark(hiMark), .loMark(loMark),
    .refAddr(refAddr), .strobe(strobe), .skipFrame(skipFrame)
  );

  crDatapath #(
    .NCOL(NCOL), .NROW(NROW), .PIX_W(PIX_W), .SAD_W(SAD_W),
    .CNT_W(CNT_W), .STEP_W(STEP_W), .QMIN(QMIN)
  ) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixData(pixData),
    .refData(refData), .sadThr(sadThr), .cntThr(thrPack),
    .blkValid(blkValid), .blkChanged(blkChanged), .blkCol(blkCol),
    .blkRow(blkRow), .frameDone(frameDone), .changedCount(changedCount),
    .quantStep(quantStep)
  );

  // R10: a dropped frame stays silent
  p_quiet_skip_r10: assert property (@(posedge clk) disable iff (!rstN)
    skipFrame |-> (!blkValid && !frameDone));
endmodule

// File: tb/blkChangeDetect_test.sv
module blkChangeDetect_test;
  localparam int W = 20;
  localparam int H = 16;
  localparam int BLK = 8;
  localparam int GAP = 400;
  localparam int NCOL = 3;
  localparam int NROW = 2;
  localparam int QMIN = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, pixValid, pixSof, pixSol;
  logic [7:0] pixData, refData;
  logic [8:0] refAddr;
  logic [15:0] bufLevel, hiMark, loMark;
  logic [13:0] sadThr;
  logic [2:0] cntThr0, cntThr1, cntThr2, cntThr3;
  logic blkValid, blkChanged, skipFrame, frameDone;
  logic [1:0] blkCol;
  logic [0:0] blkRow;
  logic [2:0] changedCount;
  logic [7:0] quantStep;

  blkChangeDetect #(
    .FRAME_W(W), .FRAME_H(H), .BLK(BLK), .PIX_W(8), .BUF_W(16),
    .STEP_W(8), .QMIN(QMIN), .MIN_GAP(GAP)
  ) uut (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixSof(pixSof), .pixSol(pixSol),
    .pixData(pixData), .refAddr(refAddr), .refData(refData), .bufLevel(bufLevel),
    .hiMark(hiMark), .loMark(loMark), .sadThr(sadThr), .cntThr0(cntThr0),
    .cntThr1(cntThr1), .cntThr2(cntThr2), .cntThr3(cntThr3), .blkValid(blkValid),
    .blkChanged(blkChanged), .blkCol(blkCol), .blkRow(blkRow), .skipFrame(skipFrame),
    .frameDone(frameDone), .changedCount(changedCount), .quantStep(quantStep)
  );

  logic [7:0] refMem [W*H];
  logic [7:0] curMem [W*H];
  assign refData = refMem[refAddr];

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int blkQ[$];
  int frmQ[$];
  bit skipModel = 1'b0;
  int lastCoded = -100000;
  int lastFrameItem = 0;
  bit running = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fillSame();
    for (int i = 0; i < W*H; i++) curMem[i] = refMem[i];
  endtask

  task automatic bump(input int x, input int y, input int delta);
    curMem[y*W + x] = 8'(int'(refMem[y*W + x]) + delta);
  endtask

  // driver: computes expectations, then streams the frame
  task automatic sendFrame(input string tag, input int idle);
    int gap, sad, cnt, lvl, d;
    bit bm, sk;
    gap = cyc - lastCoded;
    if (bufLevel > hiMark) bm = 1'b1;
    else if (bufLevel < loMark) bm = 1'b0;
    else bm = skipModel;
    skipModel = bm;
    sk = bm || (gap < GAP);
    if (!sk) begin
      lastCoded = cyc;
      cnt = 0;
      for (int r = 0; r < NROW; r++)
        for (int c = 0; c < NCOL; c++) begin
          sad = 0;
          for (int yy = r*BLK; yy < r*BLK + BLK; yy++)
            for (int xx = c*BLK; xx < c*BLK + BLK; xx++)
              if (xx < W) begin
                d = int'(curMem[yy*W + xx]) - int'(refMem[yy*W + xx]);
                sad += (d < 0) ? -d : d;
              end
          if (sad > int'(sadThr)) cnt++;
          blkQ.push_back(r*16 + c*2 + ((sad > int'(sadThr)) ? 1 : 0));
        end
      lvl = 0;
      if (cnt > int'(cntThr0)) lvl++;
      if (cnt > int'(cntThr1)) lvl++;
      if (cnt > int'(cntThr2)) lvl++;
      if (cnt > int'(cntThr3)) lvl++;
      frmQ.push_back(cnt*256 + (QMIN << lvl));
    end
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        pixValid = 1'b1;
        pixSof = (x == 0 && y == 0);
        pixSol = (x == 0);
        pixData = curMem[y*W + x];
        if (x == 0 || x == W-1) begin
          #1;
          check("R2", {tag, " refAddr"}, int'(refAddr), y*W + x);
        end
        @(negedge clk);
        if (x == 0 && y == 0)
          check((bm || !sk) ? "R8" : "R9", {tag, " skipFrame"}, int'(skipFrame), int'(sk));
      end
    pixValid = 1'b0;
    pixSof = 1'b0;
    pixSol = 1'b0;
    repeat (idle) @(negedge clk);
    if (sk)
      check("R10", {tag, " held count/step"}, int'(changedCount)*256 + int'(quantStep), lastFrameItem);
  endtask

  // monitor: pops expected results as the design emits them
  always @(negedge clk) begin
    if (running) begin
      if (blkValid) begin
        if (blkQ.size() == 0) begin
          compared++;
          mismatched++;
          $display("FAIL R10 unexpected block result: actual row %0d col %0d expected none",
                   blkRow, blkCol);
        end else
          check("R3/R4/R5", "block result",
                int'(blkRow)*16 + int'(blkCol)*2 + int'(blkChanged), blkQ.pop_front());
      end
      if (frameDone) begin
        if (frmQ.size() == 0) begin
          compared++;
          mismatched++;
          $display("FAIL R10 unexpected frameDone: actual 1 expected 0");
        end else begin
          int e;
          e = frmQ.pop_front();
          check("R6/R7", "count*256+step", int'(changedCount)*256 + int'(quantStep), e);
          lastFrameItem = e;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; pixValid = 1'b0; pixSof = 1'b0; pixSol = 1'b0; pixData = '0;
    bufLevel = 16'd0; hiMark = 16'd1000; loMark = 16'd200;
    sadThr = 14'd100;
    cntThr0 = 3'd0; cntThr1 = 3'd1; cntThr2 = 3'd3; cntThr3 = 3'd4;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        refMem[y*W + x] = 8'(20 + ((x*5 + y*3) % 100));
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1", "blkValid", int'(blkValid), 0);
    check("R1", "frameDone", int'(frameDone), 0);
    check("R1", "skipFrame", int'(skipFrame), 0);
    check("R1", "count/step", int'(changedCount)*256 + int'(quantStep), 0);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);

    // F1: still picture, nothing changes
    fillSame();
    sendFrame("F1", 100);

    // F2: threshold edge, sign, partial column (R3, R4)
    fillSame();
    bump(2, 3, 100);            // block r0 c0: sum 100, not changed
    bump(9, 1, 101);            // block r0 c1: sum 101, changed
    bump(16, 0, 40); bump(17, 0, 40); bump(18, 0, 40); bump(19, 0, 30); // r0 c2 narrow
    bump(3, 9, -15); bump(4, 12, -15); bump(5, 14, -15);
    bump(1, 10, -15); bump(6, 11, -15); bump(7, 15, -15); bump(0, 8, -15); bump(2, 13, -10);
    sendFrame("F2", 100);

    // F3: every block changed, coarsest step (R7)
    for (int i = 0; i < W*H; i++) curMem[i] = refMem[i] ^ 8'h40;
    sendFrame("F3", 100);

    // F4: buffer above high mark, dropped (R8, R10)
    bufLevel = 16'd1500;
    sendFrame("F4", 100);
    // F5: between marks, still dropped by hysteresis (R8)
    bufLevel = 16'd500;
    sendFrame("F5", 100);
    // F6: drained below low mark, coded again
    bufLevel = 16'd100;
    fillSame();
    sendFrame("F6", 10);
    // F7: starts too soon after F6 (R9)
    for (int i = 0; i < W*H; i++) curMem[i] = refMem[i] ^ 8'h40;
    sendFrame("F7", 200);
    // F8: four changed blocks, step level 3
    fillSame();
    bump(0, 0, 101); bump(12, 7, 101); bump(8, 8, 101); bump(19, 15, 101);
    sendFrame("F8", 20);

    check("R10", "leftover block items", blkQ.size(), 0);
    check("R6", "leftover frame items", frmQ.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule